// File: doc/BRIEF.md
# Weighted Median Sorter for Sixteen Serial Samples

This block takes sixteen unsigned samples, each shifted in one bit per clock on a lane of its own, together with a small unsigned weight per sample that is given in parallel. A pipelined bitonic compare-exchange network orders the samples from smallest to largest. Each weight travels alongside its sample through every exchange. Equal samples are ordered by lane number, so the result is always the same for the same inputs.

In median mode, a weight stage follows the network. It walks the ordered list from the smallest entry, one entry per clock, and keeps a running sum of the weights. It stops at the first entry where that sum reaches a threshold. By default the threshold is half the total weight, rounded up. An external threshold can replace it, so several instances can be combined by outside logic into a wider filter. In sorter mode the weight stage is skipped, and the block returns all sixteen ordered words after a fixed, shorter latency.

The input side is a valid/ready pair. `start` is the valid and `in_ready` is the ready, and an operation is accepted only on a clock where both are high. There is no back-pressure on the output. Results are announced by a single-cycle `done`, and they stay on the ports until the next operation completes.

Top module: `wmed_sort16`

## Requirements
- R1: An operation is accepted only on a clock where both `start` and `in_ready` are high. `in_ready` stays low from the cycle after acceptance through the cycle of `done`, and is high again in the cycle after `done`. A `start` raised while `in_ready` is low has no effect.
- R2: Lane i carries sample i with the most significant bit first. Bit W-1 is sampled at the first clock edge after the accepting edge, and the remaining bits follow on the next W-1 edges.
- R3: At `done`, `sorted_out` word j (bits j*W+W-1 down to j*W) holds the j-th smallest sample, so word 0 is the smallest. The values never decrease with j. This holds in both modes.
- R4: In sorter mode (`sort_only`=1), `done` is first high W+12 clock edges after the accepting edge.
- R5: In median mode, `med_val` is the sample at the first sorted position where the running weight sum reaches ceil(total/2). `wt_in` bits 4i+3 down to 4i give the weight of lane i.
- R6: Equal samples are ordered by lane, lower lane first. `med_lane` reports the input lane of the chosen sample.
- R7: In median mode, `med_rank` = m (1..16) is the 1-based sorted position of the median. `done` is first high W+m+17 edges after the accepting edge.
- R8: With `thr_ext_en`=1, `thr_ext` replaces the default threshold. If the running sum never reaches it, position 16 is chosen.
- R9: `done` is high for exactly one cycle per operation. `med_val`, `med_lane` and `med_rank` change only in a `done` cycle, and do not change in sorter mode.
- R10: `wt_in`, `sort_only`, `thr_ext_en` and `thr_ext` are sampled on the accepting edge only. Later changes do not affect that operation.
- R11: When all weights are zero, the median is sorted position 1 (m=1).
- R12: After reset, `in_ready`=1, `done`=0, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request (valid) |
| in_ready | output | 1 | Block can accept an operation |
| ser_bits | input | 16 | One serial bit per sample lane, MSB first |
| wt_in | input | 64 | Sixteen 4-bit weights, lane i at bits 4i+3:4i |
| sort_only | input | 1 | 1 = plain sorter, 0 = weighted median |
| thr_ext_en | input | 1 | Use the external threshold |
| thr_ext | input | 8 | External threshold for cascading |
| done | output | 1 | One-cycle result strobe |
| med_val | output | W | Weighted median value |
| med_lane | output | 4 | Input lane of the median |
| med_rank | output | 5 | Sorted position of the median, 1..16 |
| sorted_out | output | 16*W | Ascending sorted samples |

## Verification
The bench counts clock edges from the accepting edge and samples on falling edges. It expects `done` at exactly edge W+12 in sorter mode, and at edge W+m+17 in median mode, where m is computed in the bench. Expected values come from a lane-stable insertion sort and a running-weight walk. They are compared in the same cycle that `done` is seen. In the cycle after `done`, the bench checks that `in_ready` is high and `done` is low. After an ignored mid-operation `start`, it also watches a window long enough to cover any phantom completion.

// File: rtl/wmed_pkg.sv
package wmed_pkg;
  typedef enum logic [2:0] {
    T_IDLE,
    T_SHIFT,
    T_NET,
    T_WALK,
    T_FIN
  } top_st_e;

  typedef enum logic [1:0] {
    K_IDLE,
    K_TOT,
    K_SCAN,
    K_ALIGN
  } walk_st_e;
endpackage

// File: rtl/wmed_cx.sv
module wmed_cx #(
  parameter int EW  = 16,
  parameter int KW  = 12,
  parameter bit ASC = 1'b1
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  output logic [EW-1:0] a_o,
  output logic [EW-1:0] b_o
);
  logic a_gt;
  logic swap;

  assign a_gt = a_i[EW-1 -: KW] > b_i[EW-1 -: KW];
  // keys are unique (lane index is part of the key), so !a_gt means a < b
  assign swap = ASC ? a_gt : !a_gt;
  assign a_o  = swap ? b_i : a_i;
  assign b_o  = swap ? a_i : b_i;
endmodule

// File: rtl/wmed_bitonic.sv
module wmed_bitonic #(
  parameter int LOGN = 4,
  parameter int EW   = 16,
  parameter int KW   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic [(1<<LOGN)*EW-1:0]    in_vec,
  output logic                       out_vld,
  output logic [(1<<LOGN)*EW-1:0]    out_vec
);
  localparam int N  = 1 << LOGN;
  localparam int NS = LOGN * (LOGN + 1) / 2;

  logic [N*EW-1:0] stg [NS+1];
  logic [NS:0]     vld;

  always_ff @(posedge clk) begin
    stg[0] <= in_vec;
    if (!rst_n) vld[0] <= 1'b0;
    else        vld[0] <= in_vld;
  end

  for (genvar p = 1; p <= LOGN; p++) begin : g_merge
    for (genvar q = 0; q < p; q++) begin : g_step
      localparam int S  = p * (p - 1) / 2 + q;
      localparam int JD = 1 << (p - 1 - q);
      localparam int KB = 1 << p;
      logic [N*EW-1:0] cmb;

      for (genvar i = 0; i < N; i++) begin : g_pair
        if ((i & JD) == 0) begin : g_cx
          wmed_cx #(
            .EW (EW),
            .KW (KW),
            .ASC((i & KB) == 0)
          ) cx_i (
            .a_i(stg[S][i*EW +: EW]),
            .b_i(stg[S][(i+JD)*EW +: EW]),
            .a_o(cmb[i*EW +: EW]),
            .b_o(cmb[(i+JD)*EW +: EW])
          );
        end
      end

      always_ff @(posedge clk) begin
        stg[S+1] <= cmb;
        if (!rst_n) vld[S+1] <= 1'b0;
        else        vld[S+1] <= vld[S];
      end
    end
  end

  assign out_vld = vld[NS];
  assign out_vec = stg[NS];
endmodule

// File: rtl/wmed_walker.sv
module wmed_walker
  import wmed_pkg::*;
#(
  parameter int W     = 8,
  parameter int WW    = 4,
  parameter int LOGN  = 4,
  parameter int ALIGN = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 go,
  input  logic [(1<<LOGN)*(W+LOGN+WW)-1:0]     sorted_vec,
  input  logic                                 thr_en,
  input  logic [WW+LOGN-1:0]                   thr_val,
  output logic                                 done,
  output logic [W-1:0]                         med_val,
  output logic [LOGN-1:0]                      med_lane,
  output logic [LOGN:0]                        med_rank
);
  localparam int N   = 1 << LOGN;
  localparam int LW  = LOGN;
  localparam int EW  = W + LW + WW;
  localparam int SW  = WW + LOGN;
  localparam int CW  = $clog2(ALIGN + 1);

  walk_st_e        st;
  logic [SW-1:0]   tot;
  logic [SW-1:0]   thr;
  logic [SW-1:0]   acc;
  logic [SW-1:0]   acc_n;
  logic [SW:0]     half;
  logic [LW-1:0]   pos;
  logic [CW-1:0]   cnt;
  logic [W-1:0]    pend_val;
  logic [LW-1:0]   pend_lane;
  logic [LOGN:0]   pend_rank;
  logic [WW-1:0]   wt_at;
  logic [EW-1:0]   ent;

  always_comb begin
    tot = '0;
    for (int i = 0; i < N; i++) tot = tot + SW'(sorted_vec[i*EW +: WW]);
  end

  assign half  = ({1'b0, tot} + 1'b1) >> 1;
  assign ent   = sorted_vec[int'(pos)*EW +: EW];
  assign wt_at = ent[WW-1:0];
  assign acc_n = acc + SW'(wt_at);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= K_IDLE;
      thr       <= '0;
      acc       <= '0;
      pos       <= '0;
      cnt       <= '0;
      done      <= 1'b0;
      pend_val  <= '0;
      pend_lane <= '0;
      pend_rank <= '0;
      med_val   <= '0;
      med_lane  <= '0;
      med_rank  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        K_IDLE: if (go) st <= K_TOT;
        K_TOT: begin
          thr <= thr_en ? thr_val : half[SW-1:0];
          acc <= '0;
          pos <= '0;
          st  <= K_SCAN;
        end
        K_SCAN: begin
          acc <= acc_n;
          if (acc_n >= thr || pos == LW'(N-1)) begin
            pend_val  <= ent[WW+LW +: W];
            pend_lane <= ent[WW +: LW];
            pend_rank <= (LOGN+1)'(pos) + 1'b1;
            cnt       <= '0;
            st        <= K_ALIGN;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        K_ALIGN: begin
          if (cnt == CW'(ALIGN-1)) begin
            done     <= 1'b1;
            med_val  <= pend_val;
            med_lane <= pend_lane;
            med_rank <= pend_rank;
            st       <= K_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= K_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wmed_sort16.sv
module wmed_sort16
  import wmed_pkg::*;
#(
  parameter int W     = 8,
  parameter int WW    = 4,
  parameter int LOGN  = 4,
  parameter int ALIGN = 4,
  localparam int N    = 1 << LOGN,
  localparam int SW   = WW + LOGN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              in_ready,
  input  logic [N-1:0]      ser_bits,
  input  logic [N*WW-1:0]   wt_in,
  input  logic              sort_only,
  input  logic              thr_ext_en,
  input  logic [SW-1:0]     thr_ext,
  output logic              done,
  output logic [W-1:0]      med_val,
  output logic [LOGN-1:0]   med_lane,
  output logic [LOGN:0]     med_rank,
  output logic [N*W-1:0]    sorted_out
);
  localparam int LW  = LOGN;
  localparam int EW  = W + LW + WW;
  localparam int KW  = W + LW;
  localparam int BCW = $clog2(W + 1);

  top_st_e          st;
  logic [BCW-1:0]   bitcnt;
  logic             load_go;
  logic             sort_l;
  logic             thr_en_l;
  logic [SW-1:0]    thr_l;
  logic [N*WW-1:0]  wt_q;
  logic [W-1:0]     sh [N];
  logic [N*EW-1:0]  net_in;
  logic [N*EW-1:0]  net_out;
  logic             net_vld;
  logic [N*EW-1:0]  sorted_q;
  logic             sdone;
  logic             wk_go;
  logic             wk_done;

  // serial capture, MSB first
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (st == T_SHIFT) sh[i] <= {sh[i][W-2:0], ser_bits[i]};
    end
    assign net_in[i*EW +: EW]     = {sh[i], LW'(i), wt_q[i*WW +: WW]};
    assign sorted_out[i*W +: W]   = sorted_q[i*EW+WW+LW +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      bitcnt   <= '0;
      load_go  <= 1'b0;
      sort_l   <= 1'b0;
      thr_en_l <= 1'b0;
      thr_l    <= '0;
      wt_q     <= '0;
      sorted_q <= '0;
      sdone    <= 1'b0;
    end else begin
      load_go <= 1'b0;
      sdone   <= 1'b0;
      case (st)
        T_IDLE: begin
          if (start) begin
            st       <= T_SHIFT;
            bitcnt   <= '0;
            sort_l   <= sort_only;
            thr_en_l <= thr_ext_en;
            thr_l    <= thr_ext;
            wt_q     <= wt_in;
          end
        end
        T_SHIFT: begin
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BCW'(W-1)) begin
            st      <= T_NET;
            load_go <= 1'b1;
          end
        end
        T_NET: begin
          if (net_vld) begin
            sorted_q <= net_out;
            if (sort_l) begin
              sdone <= 1'b1;
              st    <= T_FIN;
            end else begin
              st <= T_WALK;
            end
          end
        end
        T_WALK: if (wk_done) st <= T_IDLE;
        T_FIN:  st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  wmed_bitonic #(
    .LOGN(LOGN),
    .EW  (EW),
    .KW  (KW)
  ) net_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (load_go),
    .in_vec (net_in),
    .out_vld(net_vld),
    .out_vec(net_out)
  );

  assign wk_go = net_vld && (st == T_NET) && !sort_l;

  wmed_walker #(
    .W    (W),
    .WW   (WW),
    .LOGN (LOGN),
    .ALIGN(ALIGN)
  ) walk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (wk_go),
    .sorted_vec(sorted_q),
    .thr_en    (thr_en_l),
    .thr_val   (thr_l),
    .done      (wk_done),
    .med_val   (med_val),
    .med_lane  (med_lane),
    .med_rank  (med_rank)
  );

  assign done     = sdone | wk_done;
  assign in_ready = (st == T_IDLE);
endmodule

// File: rtl/wmed_sort16_chk.sv
module wmed_sort16_chk #(
  parameter int W     = 8,
  parameter int WW    = 4,
  parameter int LOGN  = 4,
  parameter int ALIGN = 4,
  localparam int N    = 1 << LOGN,
  localparam int SW   = WW + LOGN
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_ready,
  input logic [N-1:0]      ser_bits,
  input logic [N*WW-1:0]   wt_in,
  input logic              sort_only,
  input logic              thr_ext_en,
  input logic [SW-1:0]     thr_ext,
  input logic              done,
  input logic [W-1:0]      med_val,
  input logic [LOGN-1:0]   med_lane,
  input logic [LOGN:0]     med_rank,
  input logic [N*W-1:0]    sorted_out
);
  logic [15:0] cnt;
  logic        mode_l;
  logic        asc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_l <= 1'b0;
    end else if (start && in_ready) begin
      cnt    <= '0;
      mode_l <= sort_only;
    end else if (cnt != 16'hFFFF) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    asc_ok = 1'b1;
    for (int j = 1; j < N; j++)
      if (sorted_out[j*W +: W] < sorted_out[(j-1)*W +: W]) asc_ok = 1'b0;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_ready) |=> !in_ready);

  // R1
  busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R1
  ready_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  // R4
  sort_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_l) |-> (cnt == 16'(W + 12)));

  // R7
  med_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_l) |-> (cnt == 16'(W + 17) + 16'(med_rank)));

  // R7
  rank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_l) |-> (med_rank >= 1 && med_rank <= (LOGN+1)'(N)));

  // R3
  sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> asc_ok);

  // R9
  med_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(med_val) && $stable(med_lane) && $stable(med_rank)));
endmodule

bind wmed_sort16 wmed_sort16_chk #(
  .W    (W),
  .WW   (WW),
  .LOGN (LOGN),
  .ALIGN(ALIGN)
) chk_i (.*);

// File: tb/wmed_sort16_tb_top.sv
module wmed_sort16_tb_top;
  localparam int W  = 4;
  localparam int WW = 4;
  localparam int N  = 16;
  localparam int SW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            in_ready;
  logic [N-1:0]    ser_bits = '0;
  logic [N*WW-1:0] wt_in = '0;
  logic            sort_only = 1'b0;
  logic            thr_ext_en = 1'b0;
  logic [SW-1:0]   thr_ext = '0;
  logic            done;
  logic [W-1:0]    med_val;
  logic [3:0]      med_lane;
  logic [4:0]      med_rank;
  logic [N*W-1:0]  sorted_out;

  int n_vec = 0;
  int n_bad = 0;
  int v [N];
  int w [N];
  int ord [N];
  int prev_val = 0, prev_lane = 0, prev_rank = 0;

  always #5 clk = ~clk;

  wmed_sort16 #(.W(W), .WW(WW), .LOGN(4), .ALIGN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
    .ser_bits(ser_bits), .wt_in(wt_in), .sort_only(sort_only),
    .thr_ext_en(thr_ext_en), .thr_ext(thr_ext), .done(done),
    .med_val(med_val), .med_lane(med_lane), .med_rank(med_rank),
    .sorted_out(sorted_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input bit mode, input bit oen, input int oval, input bit poke);
    int n, tot, thr, acc, m;
    // lane-stable insertion sort: R6 ordering
    for (int i = 0; i < N; i++) ord[i] = i;
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && v[ord[j-1]] > v[ord[j]]; j--) begin
        int t = ord[j]; ord[j] = ord[j-1]; ord[j-1] = t;
      end
    tot = 0;
    for (int i = 0; i < N; i++) tot += w[i];
    thr = oen ? oval : (tot + 1) / 2;
    acc = 0; m = N;
    for (int i = 0; i < N; i++) begin
      acc += w[ord[i]];
      if (acc >= thr) begin m = i + 1; break; end
    end

    @(negedge clk);
    start = 1'b1; sort_only = mode; thr_ext_en = oen; thr_ext = SW'(oval);
    for (int i = 0; i < N; i++) wt_in[i*WW +: WW] = WW'(w[i]);
    @(negedge clk);
    n = 0;
    // R10: disturb sampled-at-start inputs right after acceptance
    start = 1'b0; sort_only = ~mode; thr_ext_en = ~oen; thr_ext = ~SW'(oval);
    wt_in = ~wt_in;
    chk(in_ready == 1'b0, "R1 busy after accept", in_ready, 0);
    for (int b = W - 1; b >= 0; b--) begin
      for (int i = 0; i < N; i++) ser_bits[i] = v[i][b];   // R2 MSB first
      @(negedge clk); n++;
    end
    ser_bits = 16'hA5C3;
    if (poke) begin
      start = 1'b1;
      for (int i = 0; i < N; i++) wt_in[i*WW +: WW] = 4'hF;
      @(negedge clk); n++;
      start = 1'b0;
    end
    while (!done && n < 200) begin @(negedge clk); n++; end
    if (mode) begin
      chk(n == W + 12, "R4 sort latency", n, W + 12);
      chk(int'(med_val) == prev_val && int'(med_rank) == prev_rank,
          "R9 median held in sort mode", med_val, prev_val);
    end else begin
      chk(n == W + m + 17, "R7 median latency", n, W + m + 17);
      chk(int'(med_rank) == m, "R7 rank", med_rank, m);
      chk(int'(med_val) == v[ord[m-1]], "R5 median value", med_val, v[ord[m-1]]);
      chk(int'(med_lane) == ord[m-1], "R6 median lane", med_lane, ord[m-1]);
      prev_val = med_val; prev_lane = med_lane; prev_rank = med_rank;
    end
    for (int j = 0; j < N; j++)
      chk(int'(sorted_out[j*W +: W]) == v[ord[j]], "R3 sorted word",
          sorted_out[j*W +: W], v[ord[j]]);
    @(negedge clk);
    chk(done == 1'b0, "R9 single pulse", done, 0);
    chk(in_ready == 1'b1, "R1 ready after done", in_ready, 1);
    if (poke) begin
      bit extra = 1'b0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (done || !in_ready) extra = 1'b1;
      end
      chk(extra == 1'b0, "R1 busy start ignored", extra, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(in_ready == 1'b1, "R12 ready in reset", in_ready, 1);
    chk(done == 1'b0, "R12 done in reset", done, 0);
    chk(med_val == '0 && med_rank == '0, "R12 median zero", med_val, 0);
    chk(sorted_out == '0, "R12 sorted zero", 32'(sorted_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R12 ready after reset", in_ready, 1);

    // distinct descending values, unit weights (R5)
    for (int i = 0; i < N; i++) begin v[i] = 15 - i; w[i] = 1; end
    run_op(0, 0, 0, 0);
    // all equal values: tie order by lane (R6)
    for (int i = 0; i < N; i++) begin v[i] = 7; w[i] = 1; end
    run_op(0, 0, 0, 0);
    // all zero weights (R11)
    for (int i = 0; i < N; i++) begin v[i] = (i * 7) % 16; w[i] = 0; end
    run_op(0, 0, 0, 0);
    // override threshold unreachable and small (R8)
    for (int i = 0; i < N; i++) begin v[i] = (i * 5 + 3) % 16; w[i] = 1; end
    run_op(0, 1, 200, 0);
    run_op(0, 1, 3, 0);
    // sort mode with a busy start poke (R1, R4)
    run_op(1, 0, 0, 1);
    // median mode with a busy start poke (R1, R10)
    run_op(0, 0, 0, 1);
    // sweep: a single weighted lane at each position
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin v[i] = $urandom_range(0, 15); w[i] = (i == j) ? 9 : 0; end
      run_op(0, 0, 0, 0);
    end
    // sweep: random values, weights, modes and thresholds
    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < N; i++) begin v[i] = $urandom_range(0, 15); w[i] = $urandom_range(0, 15); end
      run_op(k % 3 == 0, k % 5 == 0, $urandom_range(0, 255), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule